// File: doc/BRIEF.md
# Data address watchpoint matcher

This block watches the load and store stream of a processor core for accesses to programmed data regions. It has two independent channels. Each channel holds a 64-bit address register and a 32-bit control register. Both are loaded and read back over a small register port. The address register gives the start of a window aligned to a doubleword. The control register sets the window length, the access types that count, and the privilege levels that count.

For every access the core presents an address, a size, a read/write flag and the current privilege level. The block compares that access with both channels in the same cycle, using only combinational logic. The core therefore learns of a hit before the access is carried out, and can suppress the access. When both channels match, the lower-numbered channel is reported.

Top module: `addr_watch`

## Requirements
- R1: After reset, all four registers read back as zero and no access raises `hit`.
- R2: A write with `cfg_sel[0]`=0 loads the whole 64-bit address register of channel `cfg_sel[1]`. A write with `cfg_sel[0]`=1 loads `cfg_wdata[31:0]` into that channel's control register. `cfg_rdata` shows the register picked by `cfg_sel`, and control readback has bits 63:32 at zero.
- R3: The window starts at the address register with bits 2:0 forced to zero. Its length is (ctrl[15:10]+1)*8 bytes, so it covers 8 to 512 bytes.
- R4: An access covers the bytes `acc_addr` through `acc_addr`+2^`acc_size`-1. It matches when any of those bytes lies inside the window, and this includes an access that starts below the window and runs into it.
- R5: A read (`acc_write`=0) can match only when ctrl[5] is set. A write can match only when ctrl[6] is set. With both bits clear the channel never matches.
- R6: `acc_priv` 0 (problem state) needs ctrl[0], 1 (supervisor) needs ctrl[1], and 2 (hypervisor) needs ctrl[2]. The value 3 never matches.
- R7: ctrl[7], the hypervisor real-address mode request, is stored and read back. It has no effect on matching.
- R8: `hit` follows the access inputs in the same cycle, and it is low whenever `acc_valid` is low.
- R9: When both channels match, `hit_chan` is 0. When no channel matches, `hit_chan` is 0.
- R10: A register write affects matching from the cycle after the write edge. In the write cycle itself the old setting still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | {channel, control-not-address} selector for write and readback |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Readback of the selected register |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 64 | Access byte address |
| acc_size | input | 2 | log2 of access size in bytes (1, 2, 4, 8) |
| acc_write | input | 1 | 1 for store, 0 for load |
| acc_priv | input | 2 | 0 problem, 1 supervisor, 2 hypervisor, 3 none |
| hit | output | 1 | Access matches a channel |
| hit_chan | output | 1 | Index of the matching channel |

## Verification
Single-byte accesses placed just outside and just inside both window edges, at the shortest and the longest lengths, separate a correct length and alignment from an off-by-one error. Eight-byte and four-byte accesses that straddle the window edges separate an overlap test from a test of the start address only. Each type enable and each privilege enable is tried alone, with the other access types, so that a crossed enable bit shows up. Matching windows on both channels, on one channel and on neither test the priority. An access issued in the same cycle as a register write shows which setting is in force.

// File: rtl/addr_watch.sv
module addr_watch #(
  parameter int AW  = 64,
  parameter int NCH = 2,
  parameter int CTW = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic [1:0]    acc_priv,
  output logic          hit,
  output logic [CW-1:0] hit_chan
);
  localparam int RNG_LSB = 10;
  localparam int RNG_W   = 6;
  localparam int WE_B    = 6;
  localparam int RE_B    = 5;
  localparam int HV_B    = 2;
  localparam int SV_B    = 1;
  localparam int PR_B    = 0;

  logic [AW-1:0]  wa_q [NCH];
  logic [CTW-1:0] wc_q [NCH];
  logic [NCH-1:0] match;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        wa_q[i] <= '0;
        wc_q[i] <= '0;
      end else if (cfg_we && cfg_sel[SW-1:1] == CW'(i)) begin
        if (cfg_sel[0]) wc_q[i] <= cfg_wdata[CTW-1:0];
        else            wa_q[i] <= cfg_wdata;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (cfg_sel[SW-1:1] == CW'(i))
        cfg_rdata = cfg_sel[0] ? AW'(wc_q[i]) : wa_q[i];
  end

  wire [AW:0] acc_lo = {1'b0, acc_addr};
  wire [AW:0] acc_hi = acc_lo + ((AW+1)'(1) << acc_size) - (AW+1)'(1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire [CTW-1:0]   c      = wc_q[g];
    wire [RNG_W-1:0] rng    = c[RNG_LSB +: RNG_W];
    wire [AW:0]      win_lo = {1'b0, wa_q[g][AW-1:3], 3'b000};
    wire [AW:0]      win_hi = win_lo + (AW+1)'({rng, 3'b111});
    wire             type_ok = acc_write ? c[WE_B] : c[RE_B];
    logic            priv_ok;
    always_comb
      case (acc_priv)
        2'd0:    priv_ok = c[PR_B];
        2'd1:    priv_ok = c[SV_B];
        2'd2:    priv_ok = c[HV_B];
        default: priv_ok = 1'b0;
      endcase
    assign match[g] = acc_valid && type_ok && priv_ok &&
                      (acc_lo <= win_hi) && (win_lo <= acc_hi);
  end

  always_comb begin
    hit_chan = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (match[i]) hit_chan = CW'(i);
  end

  assign hit = |match;
endmodule

// File: rtl/addr_watch_chk.sv
module addr_watch_chk #(
  parameter int AW = 64,
  parameter int SW = 2,
  parameter int CW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [SW-1:0] cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] cfg_rdata,
  input logic          acc_valid,
  input logic [1:0]    acc_priv,
  input logic          hit,
  input logic [CW-1:0] hit_chan
);
  p_idle_nohit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !hit);

  p_chan_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_chan == '0);

  p_priv_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_priv == 2'd3) |-> !hit);

  p_addr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel[0]) |=> (!$stable(cfg_sel) || cfg_rdata == $past(cfg_wdata)));

  p_ctrl_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel[0]) |=> (!$stable(cfg_sel) || cfg_rdata == {32'h0, $past(cfg_wdata[31:0])}));
endmodule

bind addr_watch addr_watch_chk #(.AW(AW), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
  .acc_priv(acc_priv), .hit(hit), .hit_chan(hit_chan)
);

// File: tb/addr_watch_test.sv
`timescale 1ns/1ps
module addr_watch_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [63:0] cfg_wdata = 0;
  logic [63:0] cfg_rdata;
  logic        acc_valid = 0;
  logic [63:0] acc_addr = 0;
  logic [1:0]  acc_size = 0;
  logic        acc_write = 0;
  logic [1:0]  acc_priv = 0;
  logic        hit;
  logic        hit_chan;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_watch uut (.*);

  localparam logic [63:0] ALL = 64'h67;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic isctl, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = {ch, isctl}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input string tag, input logic ch, input logic isctl, input logic [63:0] exp);
    @(negedge clk);
    cfg_sel = {ch, isctl};
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic acc(input string tag, input logic [63:0] a, input logic [1:0] sz,
                     input logic w, input logic [1:0] pv, input logic eh, input logic ec);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_size = sz; acc_write = w; acc_priv = pv;
    #1 chk({tag, " hit"}, 64'(hit), 64'(eh));
    chk({tag, " chan"}, 64'(hit_chan), 64'(ec));
    acc_valid = 0;
  endtask

  task automatic t_reset;
    rd("R1 a0", 0, 0, 0); rd("R1 c0", 0, 1, 0);
    rd("R1 a1", 1, 0, 0); rd("R1 c1", 1, 1, 0);
    acc("R1 access", 64'h0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_readback;
    wr(0, 0, 64'h1234_5678_9ABC_DEF7);
    rd("R2 addr", 0, 0, 64'h1234_5678_9ABC_DEF7);
    wr(1, 1, 64'hFFFF_FFFF_0000_00FF);
    rd("R2 ctrl", 1, 1, 64'h0000_0000_0000_00FF);
    wr(1, 1, 0);
  endtask

  task automatic t_window;
    wr(0, 0, 64'h1003);
    wr(0, 1, (64'd1 << 10) | ALL);
    acc("R3 below", 64'h0FFF, 0, 0, 1, 0, 0);
    acc("R3 first", 64'h1000, 0, 0, 1, 1, 0);
    acc("R3 last",  64'h100F, 0, 1, 1, 1, 0);
    acc("R3 after", 64'h1010, 0, 0, 1, 0, 0);
    wr(0, 1, (64'd63 << 10) | ALL);
    acc("R3 max last",  64'h11FF, 0, 0, 1, 1, 0);
    acc("R3 max after", 64'h1200, 0, 0, 1, 0, 0);
  endtask

  task automatic t_overlap;
    wr(0, 0, 64'h1000);
    wr(0, 1, ALL);
    acc("R4 spill in", 64'h0FF9, 3, 0, 1, 1, 0);
    acc("R4 just below", 64'h0FF8, 3, 0, 1, 0, 0);
    acc("R4 tail", 64'h1007, 2, 1, 1, 1, 0);
    acc("R4 past", 64'h1008, 2, 1, 1, 0, 0);
  endtask

  task automatic t_type;
    wr(0, 1, 64'h27);
    acc("R5 rd en read", 64'h1000, 0, 0, 1, 1, 0);
    acc("R5 rd en write", 64'h1000, 0, 1, 1, 0, 0);
    wr(0, 1, 64'h47);
    acc("R5 wr en write", 64'h1000, 0, 1, 1, 1, 0);
    acc("R5 wr en read", 64'h1000, 0, 0, 1, 0, 0);
    wr(0, 1, 64'h07);
    acc("R5 none read", 64'h1000, 0, 0, 1, 0, 0);
    acc("R5 none write", 64'h1000, 0, 1, 1, 0, 0);
  endtask

  task automatic t_priv;
    wr(0, 1, 64'h22);
    acc("R6 sv match", 64'h1000, 0, 0, 1, 1, 0);
    acc("R6 sv pr", 64'h1000, 0, 0, 0, 0, 0);
    acc("R6 sv hv", 64'h1000, 0, 0, 2, 0, 0);
    wr(0, 1, 64'h24);
    acc("R6 hv match", 64'h1000, 0, 0, 2, 1, 0);
    acc("R6 hv sv", 64'h1000, 0, 0, 1, 0, 0);
    wr(0, 1, 64'h21);
    acc("R6 pr match", 64'h1000, 0, 0, 0, 1, 0);
    wr(0, 1, ALL);
    acc("R6 priv3", 64'h1000, 0, 0, 3, 0, 0);
  endtask

  task automatic t_hrm;
    wr(0, 1, 64'hA7);
    rd("R7 readback", 0, 1, 64'hA7);
    acc("R7 read", 64'h1000, 0, 0, 1, 1, 0);
    acc("R7 write", 64'h1000, 0, 1, 1, 0, 0);
    acc("R7 outside", 64'h1008, 0, 0, 1, 0, 0);
  endtask

  task automatic t_valid;
    wr(0, 1, ALL);
    @(negedge clk);
    acc_valid = 0; acc_addr = 64'h1000; acc_size = 0; acc_write = 0; acc_priv = 1;
    #1 chk("R8 invalid", 64'(hit), 0);
    acc_valid = 1;
    #0.5 chk("R8 same cycle", 64'(hit), 1);
    acc_valid = 0;
  endtask

  task automatic t_prio;
    wr(1, 0, 64'h1000);
    wr(1, 1, ALL);
    acc("R9 both", 64'h1000, 0, 0, 1, 1, 0);
    wr(1, 0, 64'h2000);
    acc("R9 ch1 only", 64'h2004, 0, 0, 1, 1, 1);
    acc("R9 none", 64'h3000, 0, 0, 1, 0, 0);
    wr(1, 0, 64'h1000);
    wr(0, 1, 0);
    acc("R9 ch0 off", 64'h1000, 0, 0, 1, 1, 1);
    wr(1, 1, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'b01; cfg_wdata = ALL;
    acc_valid = 1; acc_addr = 64'h1000; acc_size = 0; acc_write = 0; acc_priv = 1;
    #1 chk("R10 old setting", 64'(hit), 0);
    @(negedge clk);
    cfg_we = 0;
    #1 chk("R10 new setting", 64'(hit), 1);
    acc_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_readback;
    t_window;
    t_overlap;
    t_type;
    t_priv;
    t_hrm;
    t_valid;
    t_prio;
    t_timing;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule